// File: doc/BRIEF.md
# ADC Channel Status, Interrupt and Trigger Logic

This block keeps the digital state around an eight-channel analog-to-digital converter. Each time the converter finishes, it presents a completion strobe with a channel number and a result. The block stores that result, marks the channel as done, and flags an overrun if the previous result was never collected. A single status word shows every done and overrun flag together, plus the interrupt flag. The interrupt request is raised when a done channel is also enabled for interrupts.

Software reaches the block through a simple register port with a one-cycle registered read. Control (word address 0) holds a 3-bit start field in bits [2:0], an edge-select bit in bit 3 (0 = rising, 1 = falling) and a burst bit in bit 4. The interrupt enables sit at address 1, bits [7:0]. The status word is at address 2. The per-channel results are at addresses 8 to 15. Reading a result returns the done flag in bit 31, the overrun flag in bit 30 and the result in bits [9:0], with all other bits zero. The block also produces a one-cycle start pulse for the converter, either on request from software or on an edge of one of six external trigger inputs.

Top module: `adc_status_ctrl`

## Requirements
- R1: The status word carries the done flags of channels 0..7 in bits [7:0], their overrun flags in bits [15:8] and the interrupt flag in bit 16. Bits [31:17] are always zero, and every bit is zero after reset.
- R2: A completion strobe for channel n stores the result and sets done[n] at the next clock edge. A read of address 8+n returns {done, overrun, 20'b0, result} one cycle after the read strobe, and that value reflects the state from before the read cycle.
- R3: A completion on a channel whose done flag is already set overwrites the stored result and sets that channel's overrun flag.
- R4: A read of address 8+n clears done[n] and overrun[n]. Reading the status word, or any other address, clears no flag.
- R5: When a completion and a result read hit the same channel in the same cycle, done stays set, overrun ends up clear, and the new result is stored.
- R6: The interrupt output equals status bit 16. It is high exactly when some channel has both its done flag and its enable bit set, and it updates on the same edge as the flags and enables it depends on.
- R7: Writing start field 001 with burst 0 produces exactly one start pulse, in the cycle after the write. The start field then reads back as 000.
- R8: With burst 0 and start field k in 010..111, trigger input k-2 is synchronized through two flops. The selected edge (rising when bit 3 is 0, falling when bit 3 is 1) gives a one-cycle start pulse after the third clock edge following the input change. The other trigger inputs are ignored.
- R9: With burst 1, or with start field 000, trigger edges produce no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | Conversion-complete strobe |
| conv_ch | input | 3 | Channel of the completed conversion |
| conv_result | input | 10 | Result value of the completed conversion |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| trig_in | input | 6 | Asynchronous external trigger inputs |
| status_word | output | 32 | Combined done/overrun/interrupt status |
| irq | output | 1 | Interrupt request |
| start_pulse | output | 1 | One-cycle conversion start request |

## Verification
The main collision is a completion strobe and a result read on the same channel in the same clock. In that case the new completion must keep done set and leave overrun clear, while the read returns the previous value. The bench forces this collision directly, both on a channel that is only done and on one that already has its overrun flag set. During a long random phase it also lets the collision arise by chance. A second collision is a trigger edge arriving in the same cycle as a control write that changes burst or the start field. A behavioural model, advanced on every clock edge, judges each cycle's status word, interrupt, start pulse and read data.

// File: rtl/adc_status_pkg.sv
package adc_status_pkg;
  localparam int START_W     = 3;
  localparam int START_NONE  = 0;
  localparam int START_NOW   = 1;
  localparam int START_TRIG0 = 2;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_INTEN  = 1;
  localparam int ADDR_STATUS = 2;

  typedef struct packed {
    logic               burst;
    logic               fall;
    logic [START_W-1:0] start;
  } ctrl_t;
endpackage

// File: rtl/adc_trig_start.sv
module adc_trig_start
  import adc_status_pkg::*;
#(
  parameter int NUM_TRIG = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  ctrl_t               ctrl,
  input  logic                imm_req,
  output logic                start_pulse
);
  logic [NUM_TRIG-1:0] sync_a, sync_b, last_b;
  logic [NUM_TRIG-1:0] sel_edge;
  logic                trig_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_a <= '0;
      sync_b <= '0;
      last_b <= '0;
    end else begin
      sync_a <= trig_in;
      sync_b <= sync_a;
      last_b <= sync_b;
    end
  end

  assign sel_edge = ctrl.fall ? (last_b & ~sync_b) : (sync_b & ~last_b);

  always_comb begin
    trig_hit = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++)
      if (ctrl.start == START_W'(START_TRIG0 + i)) trig_hit = sel_edge[i];
  end

  always_ff @(posedge clk) begin
    if (rst) start_pulse <= 1'b0;
    else     start_pulse <= imm_req | (~ctrl.burst & trig_hit);
  end
endmodule

// File: rtl/adc_chan_flags.sv
module adc_chan_flags #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [CH_W-1:0]   conv_ch,
  input  logic              clr_valid,
  input  logic [CH_W-1:0]   clr_ch,
  input  logic [NUM_CH-1:0] inten_n,
  output logic [NUM_CH-1:0] done_q,
  output logic [NUM_CH-1:0] ovr_q,
  output logic              irq_q
);
  logic [NUM_CH-1:0] done_n, ovr_n;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit, clr;
    assign hit       = conv_valid && (conv_ch == CH_W'(c));
    assign clr       = clr_valid && (clr_ch == CH_W'(c));
    assign done_n[c] = hit | (done_q[c] & ~clr);
    assign ovr_n[c]  = ~clr & (ovr_q[c] | (hit & done_q[c]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      ovr_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      ovr_q  <= ovr_n;
      irq_q  <= |(done_n & inten_n);
    end
  end
endmodule

// File: rtl/adc_result_ram.sv
module adc_result_ram #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [CH_W-1:0]  waddr,
  input  logic [RES_W-1:0] wdata,
  input  logic             re,
  input  logic [CH_W-1:0]  raddr,
  output logic [RES_W-1:0] rdata
);
  logic [RES_W-1:0] mem [NUM_CH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/adc_status_ctrl.sv
module adc_status_ctrl
  import adc_status_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int RES_W    = 10,
  parameter int NUM_TRIG = 6,
  parameter int DATA_W   = 32,
  parameter int CH_W     = $clog2(NUM_CH),
  parameter int ADDR_W   = $clog2(NUM_CH) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                conv_valid,
  input  logic [CH_W-1:0]     conv_ch,
  input  logic [RES_W-1:0]    conv_result,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_TRIG-1:0] trig_in,
  output logic [DATA_W-1:0]   status_word,
  output logic                irq,
  output logic                start_pulse
);
  localparam int STAT_USED = 2 * NUM_CH + 1;
  localparam int STAT_PAD  = DATA_W - STAT_USED;
  localparam int RES_PAD   = DATA_W - 2 - RES_W;
  localparam int CTRL_W    = $bits(ctrl_t);

  ctrl_t             ctrl_q, ctrl_wr;
  logic [NUM_CH-1:0] inten_q, inten_n;
  logic [NUM_CH-1:0] done_q, ovr_q;
  logic              irq_q;
  logic              wr_ctrl, wr_inten, rd_res, imm_req;
  logic [CH_W-1:0]   rd_ch;
  logic [RES_W-1:0]  ram_q;
  logic              sel_res_q, cap_done_q, cap_ovr_q;
  logic [DATA_W-1:0] misc_q;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_CH];

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
  assign wr_inten = reg_wr && (reg_addr == ADDR_W'(ADDR_INTEN));
  assign rd_res   = reg_rd && reg_addr[ADDR_W-1];
  assign rd_ch    = reg_addr[CH_W-1:0];
  assign ctrl_wr  = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign imm_req  = wr_ctrl && (ctrl_wr.start == START_W'(START_NOW)) && !ctrl_wr.burst;
  assign inten_n  = wr_inten ? reg_wdata[NUM_CH-1:0] : inten_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      inten_q <= '0;
    end else begin
      inten_q <= inten_n;
      if (wr_ctrl) begin
        ctrl_q <= ctrl_wr;
        if (ctrl_wr.start == START_W'(START_NOW)) ctrl_q.start <= START_W'(START_NONE);
      end
    end
  end

  adc_chan_flags #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_flags (
    .clk(clk), .rst(rst),
    .conv_valid(conv_valid), .conv_ch(conv_ch),
    .clr_valid(rd_res), .clr_ch(rd_ch),
    .inten_n(inten_n),
    .done_q(done_q), .ovr_q(ovr_q), .irq_q(irq_q)
  );

  adc_result_ram #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_ram (
    .clk(clk),
    .we(conv_valid), .waddr(conv_ch), .wdata(conv_result),
    .re(rd_res), .raddr(rd_ch), .rdata(ram_q)
  );

  adc_trig_start #(.NUM_TRIG(NUM_TRIG)) u_trig (
    .clk(clk), .rst(rst), .trig_in(trig_in),
    .ctrl(ctrl_q), .imm_req(imm_req), .start_pulse(start_pulse)
  );

  assign status_word = {{STAT_PAD{1'b0}}, irq_q, ovr_q, done_q};
  assign irq         = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_res_q  <= 1'b0;
      cap_done_q <= 1'b0;
      cap_ovr_q  <= 1'b0;
      misc_q     <= '0;
    end else if (reg_rd) begin
      sel_res_q  <= rd_res;
      cap_done_q <= done_q[rd_ch];
      cap_ovr_q  <= ovr_q[rd_ch];
      if (reg_addr == ADDR_W'(ADDR_CTRL))
        misc_q <= DATA_W'(ctrl_q);
      else if (reg_addr == ADDR_W'(ADDR_INTEN))
        misc_q <= DATA_W'(inten_q);
      else if (reg_addr == ADDR_W'(ADDR_STATUS))
        misc_q <= status_word;
      else
        misc_q <= '0;
    end
  end

  assign reg_rdata = sel_res_q ? {cap_done_q, cap_ovr_q, {RES_PAD{1'b0}}, ram_q} : misc_q;
endmodule

// File: rtl/adc_status_ctrl_chk.sv
module adc_status_ctrl_chk #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int CH_W   = 3,
  parameter int ADDR_W = 4,
  parameter int CTL_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_valid,
  input logic [CH_W-1:0]   conv_ch,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CTL_W-1:0]  reg_wdata,
  input logic [DATA_W-1:0] status_word,
  input logic              irq,
  input logic              start_pulse,
  input logic [NUM_CH-1:0] inten_q,
  input logic              burst_q
);
  logic            rd_hit, ctrl_write, imm_write;
  logic [CH_W-1:0] rd_ch;

  assign rd_hit     = reg_rd && reg_addr[ADDR_W-1];
  assign rd_ch      = reg_addr[CH_W-1:0];
  assign ctrl_write = reg_wr && (reg_addr == '0);
  assign imm_write  = ctrl_write && (reg_wdata[2:0] == 3'd1) && !reg_wdata[4];

  assert_status_pad_R1: assert property (@(posedge clk) disable iff (rst)
    status_word[DATA_W-1:2*NUM_CH+1] == '0);

  assert_irq_bit_R6: assert property (@(posedge clk) disable iff (rst)
    irq == status_word[2*NUM_CH]);

  assert_irq_mask_R6: assert property (@(posedge clk) disable iff (rst)
    irq == (|(status_word[NUM_CH-1:0] & inten_q)));

  assert_done_set_R2: assert property (@(posedge clk) disable iff (rst)
    conv_valid |=> status_word[$past(conv_ch)]);

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && status_word[conv_ch] && !(rd_hit && rd_ch == conv_ch))
      |=> status_word[NUM_CH + $past(conv_ch)]);

  assert_read_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !(conv_valid && conv_ch == rd_ch))
      |=> (!status_word[$past(rd_ch)] && !status_word[NUM_CH + $past(rd_ch)]));

  assert_collision_R5: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && rd_hit && rd_ch == conv_ch)
      |=> (status_word[$past(conv_ch)] && !status_word[NUM_CH + $past(conv_ch)]));

  assert_imm_start_R7: assert property (@(posedge clk) disable iff (rst)
    imm_write |=> start_pulse);

  assert_burst_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (burst_q && !ctrl_write) |=> !start_pulse);
endmodule

bind adc_status_ctrl adc_status_ctrl_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W), .ADDR_W(ADDR_W), .CTL_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_ch(conv_ch),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .status_word(status_word), .irq(irq), .start_pulse(start_pulse),
  .inten_q(inten_q), .burst_q(ctrl_q.burst)
);

// File: tb/adc_status_ctrl_test.sv
`timescale 1ns/1ps
module adc_status_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_valid = 1'b0;
  logic [2:0]  conv_ch = '0;
  logic [9:0]  conv_result = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, status_word;
  logic [5:0]  trig_in = '0;
  logic        irq, start_pulse;

  int n_chk = 0, n_bad = 0, pulses = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_status_ctrl uut (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_ch(conv_ch),
    .conv_result(conv_result), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trig_in(trig_in), .status_word(status_word), .irq(irq),
    .start_pulse(start_pulse)
  );

  // behavioural reference model
  bit        m_done[8], m_ovr[8];
  int        m_res[8];
  bit [7:0]  m_inten;
  bit [2:0]  m_start;
  bit        m_fall, m_burst, m_irq, m_pulse;
  bit [31:0] m_rdata;
  bit [5:0]  hist[$];

  function automatic bit [31:0] m_status();
    bit [31:0] s = '0;
    for (int i = 0; i < 8; i++) begin
      s[i] = m_done[i];
      s[8+i] = m_ovr[i];
    end
    s[16] = m_irq;
    return s;
  endfunction

  function automatic bit [31:0] m_read(int a);
    if (a >= 8) return {m_done[a-8], m_ovr[a-8], 20'b0, 10'(m_res[a-8])};
    if (a == 0) return {27'b0, m_burst, m_fall, m_start};
    if (a == 1) return {24'b0, m_inten};
    if (a == 2) return m_status();
    return '0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_done[i] = 0; m_ovr[i] = 0; end
      m_inten = 0; m_start = 0; m_fall = 0; m_burst = 0;
      m_irq = 0; m_pulse = 0; m_rdata = 0;
      hist = '{6'd0, 6'd0, 6'd0};
    end else begin
      bit [5:0] cur, prv, hit;
      bit       imm;
      bit       od[8];
      if (reg_rd) m_rdata = m_read(int'(reg_addr));
      cur = hist[1]; prv = hist[2];
      hit = m_fall ? (prv & ~cur) : (cur & ~prv);
      imm = reg_wr && reg_addr == 0 && reg_wdata[2:0] == 3'd1 && !reg_wdata[4];
      m_pulse = imm || (!m_burst && m_start >= 2 && hit[m_start-2]);
      hist.push_front(trig_in);
      void'(hist.pop_back());
      od = m_done;
      if (reg_rd && reg_addr >= 8) begin
        m_done[reg_addr-8] = 0; m_ovr[reg_addr-8] = 0;
      end
      if (conv_valid) begin
        if (od[conv_ch] && !(reg_rd && reg_addr == 8 + conv_ch)) m_ovr[conv_ch] = 1;
        m_done[conv_ch] = 1;
        m_res[conv_ch] = int'(conv_result);
      end
      if (reg_wr && reg_addr == 0) begin
        m_burst = reg_wdata[4]; m_fall = reg_wdata[3];
        m_start = (reg_wdata[2:0] == 3'd1) ? 3'd0 : reg_wdata[2:0];
      end
      if (reg_wr && reg_addr == 1) m_inten = reg_wdata[7:0];
      m_irq = 0;
      for (int i = 0; i < 8; i++) if (m_done[i] && m_inten[i]) m_irq = 1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #2;
    if (!finished) begin
      check("R1 status word", status_word, m_status());
      check("R6 irq", {31'b0, irq}, {31'b0, m_irq});
      check("R8 start pulse", {31'b0, start_pulse}, {31'b0, m_pulse});
      check("R2 read data", reg_rdata, m_rdata);
      if (start_pulse === 1'b1) pulses++;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic conv(int ch, int val);
    conv_valid = 1; conv_ch = 3'(ch); conv_result = 10'(val);
    tick();
    conv_valid = 0;
  endtask

  task automatic rd(int a);
    reg_rd = 1; reg_addr = 4'(a);
    tick();
    reg_rd = 0;
  endtask

  task automatic wr(int a, int d);
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = 32'(d);
    tick();
    reg_wr = 0;
  endtask

  initial begin
    int p0;
    tick(3);
    rst = 0;
    tick();
    check("R1 reset status", status_word, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);

    conv(2, 10'h155);
    check("R2 done set", status_word, 32'h0000_0004);
    rd(10);
    check("R2 result read", reg_rdata, 32'h8000_0155);
    check("R4 cleared by read", status_word, 32'h0);

    conv(5, 10'h0AA);
    rd(2); rd(2);
    check("R4 status read keeps done", status_word, 32'h0000_0020);
    check("R2 status via port", reg_rdata, 32'h0000_0020);
    rd(13);

    conv(1, 10'h011); conv(1, 10'h022);
    check("R3 overrun set", status_word, 32'h0000_0202);
    rd(9);
    check("R3 overwritten result", reg_rdata, 32'hC000_0022);
    check("R4 overrun cleared", status_word, 32'h0);

    conv(3, 10'h033);
    conv_valid = 1; conv_ch = 3; conv_result = 10'h044;
    reg_rd = 1; reg_addr = 11;
    tick();
    conv_valid = 0; reg_rd = 0;
    check("R5 collision done kept", status_word, 32'h0000_0008);
    check("R5 read returns old", reg_rdata, 32'h8000_0033);
    rd(11);
    check("R5 new result stored", reg_rdata, 32'h8000_0044);

    conv(4, 1); conv(4, 2);
    conv_valid = 1; conv_ch = 4; conv_result = 10'h3;
    reg_rd = 1; reg_addr = 12;
    tick();
    conv_valid = 0; reg_rd = 0;
    check("R5 collision clears overrun", status_word, 32'h0000_0010);
    rd(12);

    wr(1, 32'h04);
    conv(6, 7);
    check("R6 masked channel no irq", {31'b0, irq}, 32'h0);
    conv(2, 8);
    check("R6 enabled channel irq", {31'b0, irq}, 32'h1);
    check("R6 status bit16", status_word, 32'h0001_0044);
    rd(10);
    check("R6 irq drops on read", {31'b0, irq}, 32'h0);
    wr(1, 32'h40);
    check("R6 enable after done", {31'b0, irq}, 32'h1);
    rd(14);
    wr(1, 32'h00);

    p0 = pulses;
    wr(0, 32'h01);
    tick(2);
    check("R7 one immediate pulse", 32'(pulses - p0), 32'd1);
    rd(0);
    check("R7 start field cleared", reg_rdata, 32'h0);

    wr(0, 32'h05);
    p0 = pulses;
    trig_in[2] = 1; tick(5);
    check("R8 other trigger ignored", 32'(pulses - p0), 32'd0);
    trig_in[3] = 1; tick(5);
    check("R8 rising edge pulse", 32'(pulses - p0), 32'd1);
    trig_in[3] = 0; tick(5);
    check("R8 falling ignored when rising", 32'(pulses - p0), 32'd1);
    wr(0, 32'h0D);
    trig_in[3] = 1; tick(5);
    trig_in[3] = 0; tick(5);
    check("R8 falling edge pulse", 32'(pulses - p0), 32'd2);

    wr(0, 32'h15);
    p0 = pulses;
    trig_in[3] = 1; tick(5); trig_in[3] = 0; tick(5);
    check("R9 burst blocks trigger", 32'(pulses - p0), 32'd0);
    wr(0, 32'h00);
    trig_in = 6'h3F; tick(5); trig_in = 0; tick(5);
    check("R9 start none blocks trigger", 32'(pulses - p0), 32'd0);

    for (int k = 0; k < 4000; k++) begin
      conv_valid = ($urandom_range(0, 2) == 0);
      conv_ch    = 3'($urandom_range(0, 7));
      conv_result = 10'($urandom);
      reg_rd  = ($urandom_range(0, 2) == 0);
      reg_addr = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 3)) : 4'($urandom_range(8, 15));
      reg_wr  = ($urandom_range(0, 15) == 0);
      reg_wdata = $urandom & 32'h0000_00FF;
      if (reg_wr && reg_addr >= 8) reg_wr = 0;
      if ($urandom_range(0, 3) == 0) trig_in = trig_in ^ 6'($urandom);
      tick();
    end
    conv_valid = 0; reg_rd = 0; reg_wr = 0;
    tick(4);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule